// File: doc/BRIEF.md
# Flow-Control PAUSE Transmit Timer with Refresh

This block sits beside one Ethernet MAC port and drives both halves of IEEE 802.3x flow control. On the transmit side it watches a level-sensitive congestion input. While congestion is present, it asks the MAC to send PAUSE frames. Each request carries a programmable quanta value, and a local countdown tracks how much of the partner's pause interval remains. When the countdown falls to a programmable refresh threshold and congestion is still present, the block asks for another full-quanta PAUSE. Refreshing before expiry means the partner never resumes while the port is still congested. When congestion clears, the block sends one zero-quanta PAUSE to release the partner early.

On the receive side, a decoded PAUSE quanta value from the MAC receiver becomes a transmit-hold interval for the local transmitter. Honouring of received PAUSE frames is gated by the negotiated receive-pause setting and by an ignore control. Timing comes from a bit-time tick input. One quantum is `TICKS_PER_QUANTUM` ticks, which is 512 by default. Frame building, CRC and the data path belong to the MAC.

Transmit state machine:

| State | Meaning |
|---|---|
| `TX_IDLE` | No pause in force. |
| `TX_SEND_ON` | A full-quanta request is pending. |
| `TX_WAIT` | The countdown is running. |
| `TX_SEND_OFF` | A zero-quanta release request is pending. |

Transitions:
- `TX_IDLE` → `TX_SEND_ON` when congested and transmit pause is enabled.
- `TX_SEND_ON` → `TX_WAIT` on handshake acceptance.
- `TX_WAIT` → `TX_SEND_OFF` when congestion clears or transmit pause is disabled.
- `TX_WAIT` → `TX_SEND_ON` when the countdown is at or below the refresh threshold.
- `TX_SEND_OFF` → `TX_IDLE` on acceptance.

Top module: `pause_ctrl`

## Requirements
- R1: After reset, `req_valid` and `tx_hold` are both low.
- R2: With `cfg_tx_en` high, asserting `congested` raises `req_valid` with `req_quanta` equal to `cfg_quanta`. With `cfg_tx_en` low, no request is ever raised.
- R3: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_quanta` stays unchanged. Only one request is outstanding at a time.
- R4: On acceptance of a full-quanta request, the countdown loads `cfg_quanta` and drops by one every `TICKS_PER_QUANTUM` bit ticks. Once it is at or below `cfg_refresh` with congestion still present, a new request carrying the full `cfg_quanta` is raised. With a tick on every cycle, `req_valid` stays low for (`cfg_quanta` − `cfg_refresh`) × `TICKS_PER_QUANTUM` + 1 cycles after acceptance.
- R5: With `cfg_refresh` = 0, the refresh request is raised when the countdown expires, after `cfg_quanta` × `TICKS_PER_QUANTUM` + 1 low cycles.
- R6: When `congested` falls while the countdown runs, exactly one request with `req_quanta` = 0 is raised. After it is accepted, no further request follows.
- R7: A received PAUSE (`rx_pause_valid`) with quanta N ≠ 0 asserts `tx_hold` from the next cycle for N × `TICKS_PER_QUANTUM` bit ticks, provided `cfg_rx_en` is high and `cfg_rx_ignore` is low.
- R8: A later honoured PAUSE replaces the remaining hold time. A received quanta of 0 drops `tx_hold` on the next cycle.
- R9: With `cfg_rx_ignore` high or `cfg_rx_en` low, received PAUSE frames leave `tx_hold` low.
- R10: Without `bit_tick`, both countdowns freeze, and `tx_hold` stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One pulse per bit time |
| cfg_tx_en | input | 1 | Transmit pause negotiated |
| cfg_rx_en | input | 1 | Receive pause negotiated |
| cfg_rx_ignore | input | 1 | Ignore received PAUSE frames |
| cfg_quanta | input | QW | Quanta placed in full PAUSE requests |
| cfg_refresh | input | QW | Countdown value that triggers a refresh |
| congested | input | 1 | Level-sensitive congestion indication |
| req_valid | output | 1 | PAUSE send request |
| req_ready | input | 1 | MAC accepts the request |
| req_quanta | output | QW | Quanta for the requested frame |
| rx_pause_valid | input | 1 | Received PAUSE decoded, one-cycle pulse |
| rx_pause_quanta | input | QW | Quanta of the received PAUSE |
| tx_hold | output | 1 | Hold the local transmitter |

## Verification
The assertions take the configuration inputs as static while a request is in flight. In particular, the check that a nonzero request carries `cfg_quanta` relies on `cfg_quanta` not changing under a pending request. They also treat `rx_pause_valid` as a single-cycle pulse. The stimulus changes configuration only while the transmit machine is idle. It drives every input at the falling edge, and it raises each receive pulse for exactly one cycle.

// File: rtl/pause_pkg.sv
package pause_pkg;
    typedef enum logic [1:0] {
        TX_IDLE     = 2'd0,
        TX_SEND_ON  = 2'd1,
        TX_WAIT     = 2'd2,
        TX_SEND_OFF = 2'd3
    } tx_state_e;
endpackage

// File: rtl/pause_quantum_div.sv
// Divides bit-time ticks into quantum ticks; restartable.
module pause_quantum_div #(
    parameter int TICKS_PER_QUANTUM = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bit_tick,
    output logic q_tick
);
    localparam int CW = (TICKS_PER_QUANTUM > 1) ? $clog2(TICKS_PER_QUANTUM) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_QUANTUM - 1);

    logic [CW-1:0] cnt;

    assign q_tick = bit_tick && !clear && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (bit_tick) begin
            cnt <= q_tick ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pause_tx_fsm.sv
// Transmit-side PAUSE request sequencer with refresh countdown.
module pause_tx_fsm
    import pause_pkg::*;
#(
    parameter int QW                = 16,
    parameter int TICKS_PER_QUANTUM = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  logic          cfg_tx_en,
    input  logic [QW-1:0] cfg_quanta,
    input  logic [QW-1:0] cfg_refresh,
    input  logic          congested,
    input  logic          req_ready,
    output logic          req_valid,
    output logic [QW-1:0] req_quanta
);
    tx_state_e     state, state_nx;
    logic [QW-1:0] timer;
    logic          accept;
    logic          q_tick;
    logic          load;

    assign accept = req_valid && req_ready;
    assign load   = accept && (state == TX_SEND_ON);

    pause_quantum_div #(.TICKS_PER_QUANTUM(TICKS_PER_QUANTUM)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (load),
        .bit_tick (bit_tick),
        .q_tick   (q_tick)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:     if (cfg_tx_en && congested) state_nx = TX_SEND_ON;
            TX_SEND_ON:  if (accept) state_nx = TX_WAIT;
            TX_WAIT: begin
                if (!congested || !cfg_tx_en)  state_nx = TX_SEND_OFF;
                else if (timer <= cfg_refresh) state_nx = TX_SEND_ON;
            end
            TX_SEND_OFF: if (accept) state_nx = TX_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_valid  = 1'b0;
        req_quanta = '0;
        unique case (state)
            TX_IDLE:     ;
            TX_SEND_ON:  begin req_valid = 1'b1; req_quanta = cfg_quanta; end
            TX_WAIT:     ;
            TX_SEND_OFF: req_valid = 1'b1;
        endcase
    end

    // Countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer <= '0;
        end else if (load) begin
            timer <= cfg_quanta;
        end else if (state == TX_WAIT && q_tick && timer != '0) begin
            timer <= timer - 1'b1;
        end
    end
endmodule

// File: rtl/pause_rx_hold.sv
// Receive-side hold timer driven by received PAUSE quanta.
module pause_rx_hold #(
    parameter int QW                = 16,
    parameter int TICKS_PER_QUANTUM = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  logic          cfg_rx_en,
    input  logic          cfg_rx_ignore,
    input  logic          rx_pause_valid,
    input  logic [QW-1:0] rx_pause_quanta,
    output logic          tx_hold
);
    logic [QW-1:0] hold_cnt;
    logic          honour;
    logic          load;
    logic          q_tick;

    assign honour = cfg_rx_en && !cfg_rx_ignore;
    assign load   = honour && rx_pause_valid;

    pause_quantum_div #(.TICKS_PER_QUANTUM(TICKS_PER_QUANTUM)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (load),
        .bit_tick (bit_tick),
        .q_tick   (q_tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || !honour) begin
            hold_cnt <= '0;
        end else if (load) begin
            hold_cnt <= rx_pause_quanta;
        end else if (q_tick && hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    assign tx_hold = (hold_cnt != '0);
endmodule

// File: rtl/pause_ctrl.sv
// Top: one MAC port's PAUSE generation and PAUSE honouring.
module pause_ctrl #(
    parameter int QW                = 16,
    parameter int TICKS_PER_QUANTUM = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  logic          cfg_tx_en,
    input  logic          cfg_rx_en,
    input  logic          cfg_rx_ignore,
    input  logic [QW-1:0] cfg_quanta,
    input  logic [QW-1:0] cfg_refresh,
    input  logic          congested,
    output logic          req_valid,
    input  logic          req_ready,
    output logic [QW-1:0] req_quanta,
    input  logic          rx_pause_valid,
    input  logic [QW-1:0] rx_pause_quanta,
    output logic          tx_hold
);
    pause_tx_fsm #(.QW(QW), .TICKS_PER_QUANTUM(TICKS_PER_QUANTUM)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .cfg_tx_en   (cfg_tx_en),
        .cfg_quanta  (cfg_quanta),
        .cfg_refresh (cfg_refresh),
        .congested   (congested),
        .req_ready   (req_ready),
        .req_valid   (req_valid),
        .req_quanta  (req_quanta)
    );

    pause_rx_hold #(.QW(QW), .TICKS_PER_QUANTUM(TICKS_PER_QUANTUM)) u_rx (
        .clk             (clk),
        .rst_n           (rst_n),
        .bit_tick        (bit_tick),
        .cfg_rx_en       (cfg_rx_en),
        .cfg_rx_ignore   (cfg_rx_ignore),
        .rx_pause_valid  (rx_pause_valid),
        .rx_pause_quanta (rx_pause_quanta),
        .tx_hold         (tx_hold)
    );
endmodule

// File: rtl/pause_ctrl_checker.sv
module pause_ctrl_checker #(
    parameter int QW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_tick,
    input logic          cfg_tx_en,
    input logic          cfg_rx_en,
    input logic          cfg_rx_ignore,
    input logic [QW-1:0] cfg_quanta,
    input logic          congested,
    input logic          req_valid,
    input logic          req_ready,
    input logic [QW-1:0] req_quanta,
    input logic          rx_pause_valid,
    input logic [QW-1:0] rx_pause_quanta,
    input logic          tx_hold
);
    // R3: pending request held stable until accepted
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_quanta));

    // R2: no new request while transmit pause is disabled
    p_no_req_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_tx_en && !req_valid |=> !req_valid);

    // R4: every nonzero request carries the programmed quanta
    p_full_quanta_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_quanta != '0 |-> req_quanta == cfg_quanta);

    // R7: honoured nonzero PAUSE asserts hold next cycle
    p_hold_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pause_valid && rx_pause_quanta != '0 && cfg_rx_en && !cfg_rx_ignore
        |=> tx_hold);

    // R8: zero quanta releases the hold
    p_zero_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pause_valid && rx_pause_quanta == '0 |=> !tx_hold);

    // R9: ignored receive pause leaves the transmitter free
    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rx_ignore |=> !tx_hold);

    // R10: hold cannot fall without a bit tick or a new frame
    p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hold && !bit_tick && !rx_pause_valid && cfg_rx_en && !cfg_rx_ignore
        |=> tx_hold);
endmodule

bind pause_ctrl pause_ctrl_checker #(.QW(QW)) u_chk (.*);

// File: tb/pause_ctrl_test.sv
`timescale 1ns/1ps
module pause_ctrl_test;
    localparam int QW  = 16;
    localparam int TPQ = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_tick = 1'b1;
    logic          cfg_tx_en = 1'b0;
    logic          cfg_rx_en = 1'b0;
    logic          cfg_rx_ignore = 1'b0;
    logic [QW-1:0] cfg_quanta = 16'd6;
    logic [QW-1:0] cfg_refresh = 16'd4;
    logic          congested = 1'b0;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic [QW-1:0] req_quanta;
    logic          rx_pause_valid = 1'b0;
    logic [QW-1:0] rx_pause_quanta = '0;
    logic          tx_hold;

    int n_tests = 0;
    int n_bad   = 0;

    always #2 clk = ~clk;

    pause_ctrl #(.QW(QW), .TICKS_PER_QUANTUM(TPQ)) uut (.*);

    // {quanta[15:0], ignore, rx_en, expected hold cycles[7:0]}
    localparam int NV = 6;
    localparam logic [25:0] RX_VEC [NV] = '{
        {16'd3, 1'b0, 1'b1, 8'd12},
        {16'd1, 1'b0, 1'b1, 8'd4},
        {16'd7, 1'b0, 1'b1, 8'd28},
        {16'd5, 1'b1, 1'b1, 8'd0},
        {16'd5, 1'b0, 1'b0, 8'd0},
        {16'd0, 1'b0, 1'b1, 8'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rx_send(input logic [QW-1:0] q);
        rx_pause_quanta = q;
        rx_pause_valid  = 1'b1;
        @(negedge clk);
        rx_pause_valid  = 1'b0;
    endtask

    function automatic int count_hold();
        return 0;
    endfunction

    task automatic hold_len(output int n);
        n = 0;
        while (tx_hold && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic gap_len(output int n);
        n = 0;
        while (!req_valid && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic accept_one();
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_bad);
        $finish;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_tests++;
        n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 req_valid", int'(req_valid), 0);
        check("R1 tx_hold", int'(tx_hold), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Receive table walk: R7, R9, R8
        for (int i = 0; i < NV; i++) begin
            cfg_rx_ignore = RX_VEC[i][9];
            cfg_rx_en     = RX_VEC[i][8];
            @(negedge clk);
            rx_send(RX_VEC[i][25:10]);
            hold_len(n);
            check($sformatf("R7/R9 vector %0d hold", i), n, int'(RX_VEC[i][7:0]));
        end
        cfg_rx_en = 1'b1;
        cfg_rx_ignore = 1'b0;
        @(negedge clk);

        // R8: replacement of remaining hold
        rx_send(16'd10);
        repeat (3) @(negedge clk);
        rx_send(16'd1);
        hold_len(n);
        check("R8 replace", n, 4);

        // R8: zero quanta releases immediately
        rx_send(16'd9);
        repeat (2) @(negedge clk);
        rx_send(16'd0);
        check("R8 zero release", int'(tx_hold), 0);

        // R10: no bit tick freezes the hold
        bit_tick = 1'b0;
        @(negedge clk);
        rx_send(16'd2);
        repeat (40) @(negedge clk);
        check("R10 frozen hold", int'(tx_hold), 1);
        bit_tick = 1'b1;
        hold_len(n);
        check("R10 resumed hold", n, 8);

        // R2: disabled transmit pause never requests
        congested = 1'b1;
        n = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (req_valid) n++;
        end
        check("R2 disabled no request", n, 0);

        // R2/R3: request raised and held without ready
        cfg_tx_en = 1'b1;
        @(negedge clk);
        check("R2 request raised", int'(req_valid), 1);
        check("R2 request quanta", int'(req_quanta), 6);
        repeat (5) @(negedge clk);
        check("R3 held valid", int'(req_valid), 1);
        check("R3 held quanta", int'(req_quanta), 6);

        // R4: refresh at threshold
        accept_one();
        gap_len(n);
        check("R4 refresh gap", n, (6 - 4) * TPQ + 1);
        check("R4 refresh quanta", int'(req_quanta), 6);

        // R6: release on congestion drop
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        congested = 1'b0;
        @(negedge clk);
        check("R6 release valid", int'(req_valid), 1);
        check("R6 release quanta", int'(req_quanta), 0);
        accept_one();
        n = 0;
        for (int k = 0; k < 30; k++) begin
            if (req_valid) n++;
            @(negedge clk);
        end
        check("R6 no further request", n, 0);

        // R5: refresh at expiry with zero threshold
        cfg_quanta  = 16'd3;
        cfg_refresh = 16'd0;
        congested   = 1'b1;
        @(negedge clk);
        check("R5 request quanta", int'(req_quanta), 3);
        accept_one();
        gap_len(n);
        check("R5 expiry gap", n, 3 * TPQ + 1);
        check("R5 refresh quanta", int'(req_quanta), 3);

        finish_run();
    end
endmodule